// File: doc/BRIEF.md
# Packet Error Data Capture Register

This block sits beside an inbound flit stream in which every packet starts with a header flit and carries zero or more 64-bit data flits after it. A separate checker flags an error together with the header flit and supplies an error code. The header also carries a packet-kind field. On the first error it sees, the block records one 64-bit flit of that packet in a software-readable register. Which flit it records depends on the error code and on the packet kind. Some error classes leave the register contents unspecified. For those the block only marks the register as holding an error and does not write new data.

Flits are numbered from 1 at the header of each packet. The block decodes the error code and packet kind when the header arrives and stores the flit number it is waiting for. It then latches the payload when that flit arrives. If the packet ends first, nothing is recorded. Once a capture or lock has happened, the valid flag holds the register until software pulses the clear input. Error detection, packet routing and the rest of the register file are outside this block.

Top module: `pkt_err_capture`

## Requirements
- R1: After reset `err_valid_o` is 0 and `err_data_o` is 0.
- R2: An error with code 0 (bad line invalidate) latches flit 2 of the packet, for any packet kind.
- R3: Codes 1 (request bad address) and 2 (request bad data) latch flit 3 for kind 3 (vector read request) and kind 4 (vector write request). They latch flit 2 for kind 1 (PIO write request) and kind 2 (line invalidate). For any other kind they record nothing and `err_valid_o` stays 0.
- R4: Code 3 (reply bad data) latches flit 3 of the packet.
- R5: Codes 4 (reply too long) and 5 (request too long) latch flit 3 for kinds 3, 4 and 5 (vector reply). They latch flit 2 for the other kinds, with one exception covered by R6.
- R6: Codes 6 and 7 (reply/request too short), codes 8 and 9 (reply/request bad command), and code 5 with kind 0 (PIO read request) all have unspecified contents. For these, `err_valid_o` becomes 1 on the edge that takes the header, and `err_data_o` keeps its previous value.
- R7: While `err_valid_o` is 1, any further error leaves both `err_valid_o` and `err_data_o` unchanged.
- R8: A `sw_clear` pulse drives `err_valid_o` to 0 on the next edge and keeps `err_data_o`. It also discards a pending capture, including one whose target flit arrives in the same cycle.
- R9: Flit numbers restart at 1 on every header flit. The flit that is latched is counted from the start of the erroneous packet, whatever packets came before it.
- R10: If the packet ends (`flit_tail`) before its target flit, nothing is recorded and `err_valid_o` stays 0. A later error can then capture normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flit_valid | input | 1 | A flit is present this cycle |
| flit_head | input | 1 | The flit is a packet header (flit 1) |
| flit_tail | input | 1 | The flit is the last of its packet |
| flit_data | input | 64 | Flit payload |
| hdr_kind | input | 3 | Packet kind, valid with the header |
| hdr_err | input | 1 | Error flagged for this packet, valid with the header |
| hdr_err_code | input | 4 | Error class, valid with the header |
| sw_clear | input | 1 | Software clear of the valid flag |
| err_valid_o | output | 1 | Register holds a recorded error |
| err_data_o | output | 64 | Captured flit payload |

## Verification
The bench sends each error code with the packet kinds that move the target between flit 2 and flit 3. Every flit carries a distinct payload, so a design that latches the header or the wrong flit returns a value that does not match. It sends packets that end before their target flit; a design that keeps waiting would latch a flit from the next packet. It sends a long clean packet before a faulty one; a design with a counter that does not restart would pick the wrong flit. It also raises clear in the same cycle as a target flit, and sends errors while the register is already held. A design that lets the capture win, or that overwrites the held register, shows a set flag or changed data.

// File: rtl/errcap_pkg.sv
// Shared encodings for the packet error data capture block.
// Assumes the checker presents error code and packet kind with the header.
package errcap_pkg;

    localparam int CODE_W = 4;
    localparam int KIND_W = 3;

    // Error classes reported by the upstream checker
    typedef enum logic [CODE_W-1:0] {
        ERR_INVAL_BAD = 4'd0,
        ERR_REQ_ADDR  = 4'd1,
        ERR_REQ_DATA  = 4'd2,
        ERR_RSP_DATA  = 4'd3,
        ERR_RSP_LONG  = 4'd4,
        ERR_REQ_LONG  = 4'd5,
        ERR_RSP_SHORT = 4'd6,
        ERR_REQ_SHORT = 4'd7,
        ERR_RSP_CMD   = 4'd8,
        ERR_REQ_CMD   = 4'd9
    } err_code_e;

    // Packet kinds carried by the header
    typedef enum logic [KIND_W-1:0] {
        KIND_PIO_RD  = 3'd0,
        KIND_PIO_WR  = 3'd1,
        KIND_INVAL   = 3'd2,
        KIND_VEC_RD  = 3'd3,
        KIND_VEC_WR  = 3'd4,
        KIND_VEC_RSP = 3'd5,
        KIND_PIO_RSP = 3'd6
    } pkt_kind_e;

    // What to do when an erroneous header arrives
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOCK = 2'd1,
        ACT_ARM  = 2'd2
    } cap_act_e;

endpackage

// File: rtl/errcap_flit_tracker.sv
// Flit position tracker.
// Numbers every flit inside a packet, starting at 1 on the header. The
// counter saturates at its top value. Body flits that arrive outside any
// packet get number 0, so they never match a target.
// Assumes: flit_head marks flit 1 and flit_tail marks the last flit.
module errcap_flit_tracker #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flit_valid,
    input  logic             flit_head,
    input  logic             flit_tail,
    output logic [IDX_W-1:0] cur_idx
);

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [IDX_W-1:0] cnt_q;
    logic             in_pkt_q;
    logic [IDX_W-1:0] next_body;

    // Number of the next body flit, saturating at the top value
    always_comb begin
        next_body = (cnt_q == IDX_MAX) ? cnt_q : cnt_q + IDX_ONE;
    end

    // Number of the flit on the bus this cycle
    always_comb begin
        if (!flit_valid)     cur_idx = '0;
        else if (flit_head)  cur_idx = IDX_ONE;
        else if (in_pkt_q)   cur_idx = next_body;
        else                 cur_idx = '0;
    end

    // Track the position within the packet and whether a packet is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            in_pkt_q <= 1'b0;
        end else if (flit_valid) begin
            if (flit_head) begin
                cnt_q    <= IDX_ONE;
                in_pkt_q <= !flit_tail;
            end else if (in_pkt_q) begin
                cnt_q    <= next_body;
                in_pkt_q <= !flit_tail;
            end
        end
    end

endmodule

// File: rtl/errcap_target_decode.sv
// Target decoder.
// Maps error code and packet kind to an action: record nothing, lock the
// register without data, or arm a capture of a given flit number.
// Assumes: inputs are only meaningful while hdr_err is high.
module errcap_target_decode
    import errcap_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              hdr_err,
    input  logic [CODE_W-1:0] hdr_err_code,
    input  logic [KIND_W-1:0] hdr_kind,
    output cap_act_e          act,
    output logic [IDX_W-1:0]  tgt
);

    localparam logic [IDX_W-1:0] FLIT_2 = IDX_W'(2);
    localparam logic [IDX_W-1:0] FLIT_3 = IDX_W'(3);

    logic is_vec_req;
    logic is_vec_any;

    // Classify the packet kind
    always_comb begin
        is_vec_req = (hdr_kind == KIND_VEC_RD) || (hdr_kind == KIND_VEC_WR);
        is_vec_any = is_vec_req || (hdr_kind == KIND_VEC_RSP);
    end

    // Choose the action and target flit for this error
    always_comb begin
        act = ACT_NONE;
        tgt = '0;
        if (hdr_err) begin
            case (err_code_e'(hdr_err_code))
                ERR_INVAL_BAD: begin
                    act = ACT_ARM;
                    tgt = FLIT_2;
                end
                ERR_REQ_ADDR, ERR_REQ_DATA: begin
                    if (is_vec_req) begin
                        act = ACT_ARM;
                        tgt = FLIT_3;
                    end else if (hdr_kind == KIND_PIO_WR || hdr_kind == KIND_INVAL) begin
                        act = ACT_ARM;
                        tgt = FLIT_2;
                    end
                end
                ERR_RSP_DATA: begin
                    act = ACT_ARM;
                    tgt = FLIT_3;
                end
                ERR_RSP_LONG: begin
                    act = ACT_ARM;
                    tgt = is_vec_any ? FLIT_3 : FLIT_2;
                end
                ERR_REQ_LONG: begin
                    if (hdr_kind == KIND_PIO_RD) begin
                        act = ACT_LOCK;
                    end else begin
                        act = ACT_ARM;
                        tgt = is_vec_any ? FLIT_3 : FLIT_2;
                    end
                end
                ERR_RSP_SHORT, ERR_REQ_SHORT, ERR_RSP_CMD, ERR_REQ_CMD: begin
                    act = ACT_LOCK;
                end
                default: begin
                    act = ACT_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/errcap_capture_reg.sv
// Capture register.
// Holds the armed target and the software-visible valid flag and data.
// Arms on an erroneous header only while the valid flag is clear. Latches
// the flit whose number matches the target. Disarms at the packet tail.
// Clear takes priority over everything else.
// Assumes: header and body strobes are never high together.
module errcap_capture_reg
    import errcap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_fire,
    input  logic              body_fire,
    input  logic              flit_tail,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [DATA_W-1:0] flit_data,
    input  cap_act_e          act,
    input  logic [IDX_W-1:0]  tgt,
    input  logic              sw_clear,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    logic             armed_q;
    logic [IDX_W-1:0] tgt_q;
    logic             hit;

    // A body flit matches the armed target
    always_comb begin
        hit = body_fire && armed_q && (cur_idx == tgt_q);
    end

    // Arm, capture, lock and clear sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            tgt_q   <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (sw_clear) begin
            valid_o <= 1'b0;
            armed_q <= 1'b0;
        end else if (hdr_fire) begin
            armed_q <= 1'b0;
            if (!valid_o && act == ACT_LOCK) begin
                valid_o <= 1'b1;
            end else if (!valid_o && act == ACT_ARM && !flit_tail) begin
                armed_q <= 1'b1;
                tgt_q   <= tgt;
            end
        end else if (body_fire) begin
            if (hit) begin
                data_o  <= flit_data;
                valid_o <= 1'b1;
                armed_q <= 1'b0;
            end else if (flit_tail) begin
                armed_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pkt_err_capture.sv
// Packet error data capture, top level.
// Ties together the flit tracker, the target decoder and the capture
// register. Header strobes go to the decoder, and every flit is numbered
// for the capture register.
// Assumes: error code and kind are valid in the header cycle.
module pkt_err_capture
    import errcap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flit_valid,
    input  logic              flit_head,
    input  logic              flit_tail,
    input  logic [DATA_W-1:0] flit_data,
    input  logic [KIND_W-1:0] hdr_kind,
    input  logic              hdr_err,
    input  logic [CODE_W-1:0] hdr_err_code,
    input  logic              sw_clear,
    output logic              err_valid_o,
    output logic [DATA_W-1:0] err_data_o
);

    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] tgt;
    cap_act_e         act;
    logic             hdr_fire;
    logic             body_fire;

    // Split flit strobes into header and body
    always_comb begin
        hdr_fire  = flit_valid && flit_head;
        body_fire = flit_valid && !flit_head;
    end

    errcap_flit_tracker #(.IDX_W(IDX_W)) tracker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flit_valid (flit_valid),
        .flit_head  (flit_head),
        .flit_tail  (flit_tail),
        .cur_idx    (cur_idx)
    );

    errcap_target_decode #(.IDX_W(IDX_W)) decode_i (
        .hdr_err      (hdr_err),
        .hdr_err_code (hdr_err_code),
        .hdr_kind     (hdr_kind),
        .act          (act),
        .tgt          (tgt)
    );

    errcap_capture_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_fire  (hdr_fire),
        .body_fire (body_fire),
        .flit_tail (flit_tail),
        .cur_idx   (cur_idx),
        .flit_data (flit_data),
        .act       (act),
        .tgt       (tgt),
        .sw_clear  (sw_clear),
        .valid_o   (err_valid_o),
        .data_o    (err_data_o)
    );

endmodule

// File: rtl/errcap_checker.sv
// Assertion checker for pkt_err_capture, attached through bind.
module errcap_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flit_valid,
    input logic              flit_head,
    input logic [DATA_W-1:0] flit_data,
    input logic              sw_clear,
    input logic              err_valid_o,
    input logic [DATA_W-1:0] err_data_o
);

    // R8: clear drops the flag on the next edge
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> !err_valid_o);

    // R7: a held flag stays set until cleared
    assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid_o && !sw_clear) |=> err_valid_o);

    // R7 R8: held data never changes, not even across a clear
    assert_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |=> $stable(err_data_o));

    // R6: data moves only after a body flit
    assert_data_only_on_body_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flit_valid && !flit_head) |=> $stable(err_data_o));

    // R9: a body-flit capture holds exactly that flit's payload
    assert_capture_payload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_valid_o) && $past(flit_valid) && !$past(flit_head))
            |-> (err_data_o == $past(flit_data)));

endmodule

bind pkt_err_capture errcap_checker #(.DATA_W(DATA_W)) errcap_chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flit_valid  (flit_valid),
    .flit_head   (flit_head),
    .flit_data   (flit_data),
    .sw_clear    (sw_clear),
    .err_valid_o (err_valid_o),
    .err_data_o  (err_data_o)
);

// File: tb/pkt_err_capture_tb_top.sv
module pkt_err_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flit_valid = 1'b0;
    logic        flit_head = 1'b0;
    logic        flit_tail = 1'b0;
    logic [63:0] flit_data = '0;
    logic [2:0]  hdr_kind = '0;
    logic        hdr_err = 1'b0;
    logic [3:0]  hdr_err_code = '0;
    logic        sw_clear = 1'b0;
    logic        err_valid_o;
    logic [63:0] err_data_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [63:0] held;

    always #2.5 clk = ~clk;

    pkt_err_capture dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flit_valid   (flit_valid),
        .flit_head    (flit_head),
        .flit_tail    (flit_tail),
        .flit_data    (flit_data),
        .hdr_kind     (hdr_kind),
        .hdr_err      (hdr_err),
        .hdr_err_code (hdr_err_code),
        .sw_clear     (sw_clear),
        .err_valid_o  (err_valid_o),
        .err_data_o   (err_data_o)
    );

    function automatic logic [63:0] pay(input logic [31:0] base, input int idx);
        return {base, 32'(idx)};
    endfunction

    task automatic check(input string req, input logic ev, input logic [63:0] ed);
        n_checks++;
        if (err_valid_o !== ev || err_data_o !== ed) begin
            n_fails++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, err_valid_o, err_data_o, ev, ed);
        end
    endtask

    // Send one packet of n flits; flit i carries pay(base,i); ends on a negedge
    task automatic send_pkt(input logic [2:0] kind, input logic err, input logic [3:0] code,
                            input int n, input logic [31:0] base);
        for (int i = 1; i <= n; i++) begin
            flit_valid   = 1'b1;
            flit_head    = (i == 1);
            flit_tail    = (i == n);
            flit_data    = pay(base, i);
            hdr_kind     = kind;
            hdr_err      = err && (i == 1);
            hdr_err_code = code;
            @(negedge clk);
        end
        flit_valid = 1'b0;
        flit_head  = 1'b0;
        flit_tail  = 1'b0;
        hdr_err    = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clear();
        sw_clear = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", 1'b0, 64'd0);
        held = 64'd0;
    endtask

    task automatic t_inval();
        send_pkt(3'd2, 1'b1, 4'd0, 3, 32'h1000);
        held = pay(32'h1000, 2);
        check("R2 inval flit2", 1'b1, held);
        do_clear();
        check("R8 clear keeps data", 1'b0, held);
    endtask

    task automatic t_req_addr_data();
        send_pkt(3'd1, 1'b1, 4'd1, 3, 32'h2000);
        held = pay(32'h2000, 2);
        check("R3 pio write addr flit2", 1'b1, held);
        do_clear();
        send_pkt(3'd3, 1'b1, 4'd2, 4, 32'h2100);
        held = pay(32'h2100, 3);
        check("R3 vec read data flit3", 1'b1, held);
        do_clear();
        send_pkt(3'd4, 1'b1, 4'd1, 4, 32'h2200);
        held = pay(32'h2200, 3);
        check("R3 vec write addr flit3", 1'b1, held);
        do_clear();
        send_pkt(3'd0, 1'b1, 4'd1, 3, 32'h2300);
        check("R3 pio read no capture", 1'b0, held);
    endtask

    task automatic t_rsp_data();
        send_pkt(3'd6, 1'b1, 4'd3, 4, 32'h3000);
        held = pay(32'h3000, 3);
        check("R4 reply data flit3", 1'b1, held);
        do_clear();
    endtask

    task automatic t_long();
        send_pkt(3'd5, 1'b1, 4'd4, 4, 32'h4000);
        held = pay(32'h4000, 3);
        check("R5 vec reply long flit3", 1'b1, held);
        do_clear();
        send_pkt(3'd6, 1'b1, 4'd4, 3, 32'h4100);
        held = pay(32'h4100, 2);
        check("R5 pio reply long flit2", 1'b1, held);
        do_clear();
        send_pkt(3'd1, 1'b1, 4'd5, 3, 32'h4200);
        held = pay(32'h4200, 2);
        check("R5 pio write long flit2", 1'b1, held);
        do_clear();
    endtask

    task automatic t_undef();
        send_pkt(3'd5, 1'b1, 4'd6, 4, 32'h5000);
        check("R6 short locks only", 1'b1, held);
        do_clear();
        send_pkt(3'd0, 1'b1, 4'd5, 3, 32'h5100);
        check("R6 pio read long locks only", 1'b1, held);
        do_clear();
        // Lock on the header edge: flag high before the next flit
        flit_valid = 1'b1; flit_head = 1'b1; flit_tail = 1'b0;
        flit_data = pay(32'h5200, 1); hdr_kind = 3'd1; hdr_err = 1'b1; hdr_err_code = 4'd9;
        @(negedge clk);
        check("R6 bad cmd lock timing", 1'b1, held);
        flit_head = 1'b0; hdr_err = 1'b0; flit_tail = 1'b1; flit_data = pay(32'h5200, 2);
        @(negedge clk);
        flit_valid = 1'b0; flit_tail = 1'b0;
        @(negedge clk);
        check("R6 bad cmd data kept", 1'b1, held);
        do_clear();
    endtask

    task automatic t_first_only();
        send_pkt(3'd2, 1'b1, 4'd0, 3, 32'h6000);
        held = pay(32'h6000, 2);
        send_pkt(3'd5, 1'b1, 4'd3, 4, 32'h6100);
        check("R7 second error ignored", 1'b1, held);
        send_pkt(3'd1, 1'b1, 4'd8, 2, 32'h6200);
        check("R7 second lock ignored", 1'b1, held);
        do_clear();
    endtask

    task automatic t_restart();
        send_pkt(3'd1, 1'b0, 4'd0, 6, 32'h7000);
        send_pkt(3'd3, 1'b1, 4'd2, 5, 32'h7100);
        held = pay(32'h7100, 3);
        check("R9 index restarts", 1'b1, held);
        do_clear();
    endtask

    task automatic t_short_pkt();
        send_pkt(3'd2, 1'b1, 4'd0, 1, 32'h8000);
        send_pkt(3'd1, 1'b0, 4'd0, 3, 32'h8100);
        check("R10 header-only no capture", 1'b0, held);
        send_pkt(3'd5, 1'b1, 4'd3, 2, 32'h8200);
        send_pkt(3'd1, 1'b0, 4'd0, 4, 32'h8300);
        check("R10 two-flit no capture", 1'b0, held);
        send_pkt(3'd2, 1'b1, 4'd0, 2, 32'h8400);
        held = pay(32'h8400, 2);
        check("R10 later error captures", 1'b1, held);
        do_clear();
    endtask

    task automatic t_clear_collide();
        flit_valid = 1'b1; flit_head = 1'b1; flit_tail = 1'b0;
        flit_data = pay(32'h9000, 1); hdr_kind = 3'd2; hdr_err = 1'b1; hdr_err_code = 4'd0;
        @(negedge clk);
        flit_head = 1'b0; hdr_err = 1'b0; flit_data = pay(32'h9000, 2); sw_clear = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0; flit_tail = 1'b1; flit_data = pay(32'h9000, 3);
        @(negedge clk);
        flit_valid = 1'b0; flit_tail = 1'b0;
        @(negedge clk);
        check("R8 clear beats capture", 1'b0, held);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inval();
        t_req_addr_data();
        t_rsp_data();
        t_long();
        t_undef();
        t_first_only();
        t_restart();
        t_short_pkt();
        t_clear_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule